// File: doc/BRIEF.md
# Stop-Grant and Sleep Power Controller

This block decides which clock domains of a processor core may run. It watches two asynchronous request levels, one asking the core to stop its clock and one asking it to sleep, plus a synchronous indication that the bus clock has been lost. From these it drives three clock-gate enables (core units, bus and interrupt-controller units, PLL), a flag that says whether snoops and interrupts may be serviced, and the current state code.

There are three normal states. Running keeps every domain alive. Stop-Grant turns off only the core units; the bus side keeps snooping and taking interrupts. A one-cycle request to send an acknowledge transaction on the bus is raised each time Stop-Grant is entered from Running. Sleep can only be reached from Stop-Grant and keeps only the PLL alive; snoops and interrupts are not recognized there. A fourth state, Halted, is entered when the bus clock is lost and is left only through reset. The stop-clock request never gates the bus clock itself: it only steers the core enable.

Both asynchronous requests pass through a two-flop synchronizer before the state register, so a change of either request takes effect at the third rising clock edge after it is applied. The bus-clock-lost input is already synchronous and acts on the next edge.

Top module: `lp_state_ctrl`

## Requirements
- R1: While and after reset (rst_n low), state is 0 (Running), core_clk_en, bus_clk_en and pll_en are 1, snoop_ok is 1 and ack_req is 0.
- R2: In Running, an asserted stop_req moves the state to 1 (Stop-Grant) and ack_req is high for exactly one cycle per such entry; no other transition raises ack_req.
- R3: In Stop-Grant, core_clk_en is 0 while bus_clk_en, pll_en and snoop_ok stay 1.
- R4: In Stop-Grant with stop_req still asserted, an asserted sleep_req moves the state to 2 (Sleep); if stop_req is deasserted, the return to Running wins over sleep_req.
- R5: In Sleep, core_clk_en, bus_clk_en and snoop_ok are 0 and pll_en is 1.
- R6: Sleep is left only when sleep_req is deasserted (to Stop-Grant, without an ack_req), on bus clock loss, or by reset; stop_req deassertion alone leaves the state in Sleep.
- R7: In Stop-Grant, deasserting stop_req returns the state to 0 (Running) with all three enables and snoop_ok at 1.
- R8: sleep_req asserted while in Running has no effect on state, enables, snoop_ok or ack_req.
- R9: bclk_lost high at a rising edge moves the state to 3 (Halted) at that edge from any state; Halted has core_clk_en, bus_clk_en and snoop_ok at 0, pll_en at 1, and is held until reset whatever the requests do.
- R10: A change of stop_req or sleep_req becomes visible in state at the third rising edge after it is applied and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Asynchronous stop-clock request, active high |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| bclk_lost | input | 1 | Synchronous bus-clock-lost indication |
| core_clk_en | output | 1 | Gate enable for core-unit clocks |
| bus_clk_en | output | 1 | Gate enable for bus and interrupt-controller clocks |
| pll_en | output | 1 | Enable for the PLL |
| ack_req | output | 1 | One-cycle request to issue the stop acknowledge transaction |
| snoop_ok | output | 1 | Snoops and interrupts may be serviced |
| state | output | 2 | Current state: 0 Running, 1 Stop-Grant, 2 Sleep, 3 Halted |

## Verification
The bench walks every three-step sequence of the four request combinations from reset, so it reaches Sleep both directly through Stop-Grant and with the sleep request raised early in Running, and it leaves Sleep with both requests dropped at once. A design that let sleep act from Running would jump straight to Sleep, one that left Sleep on a stop-clock drop would skip back to Running, and one that re-issued the acknowledge on a Sleep-to-Stop-Grant return would show two pulses where one is expected. Bus-clock loss is applied from each state and followed by request changes, catching a Halted state that leaks out, and the exact edge of each change is sampled so a synchronizer of the wrong depth shows up.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STOPG = 2'd1,
    ST_SLEEP = 2'd2,
    ST_HALT  = 2'd3
  } lpc_state_e;

  typedef struct packed {
    logic core;
    logic bus;
    logic pll;
    logic snoop;
  } lpc_gates_t;
endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_s,
  input  logic       sleep_s,
  input  logic       bclk_lost,
  output lpc_state_e cur,
  output logic       ack_pulse
);
  lpc_state_e nxt;

  always_comb begin
    nxt = cur;
    if (bclk_lost) begin
      nxt = ST_HALT;
    end else begin
      unique case (cur)
        ST_RUN:   if (stop_s) nxt = ST_STOPG;
        ST_STOPG: begin
          if (!stop_s)      nxt = ST_RUN;
          else if (sleep_s) nxt = ST_SLEEP;
        end
        ST_SLEEP: if (!sleep_s) nxt = ST_STOPG;
        ST_HALT:  nxt = ST_HALT;
        default:  nxt = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= ST_RUN;
      ack_pulse <= 1'b0;
    end else begin
      cur       <= nxt;
      ack_pulse <= (cur == ST_RUN) && (nxt == ST_STOPG);
    end
  end
endmodule

// File: rtl/lpc_gate_dec.sv
module lpc_gate_dec
  import lpc_pkg::*;
(
  input  lpc_state_e cur,
  output lpc_gates_t gates
);
  always_comb begin
    unique case (cur)
      ST_RUN:   gates = '{core: 1'b1, bus: 1'b1, pll: 1'b1, snoop: 1'b1};
      ST_STOPG: gates = '{core: 1'b0, bus: 1'b1, pll: 1'b1, snoop: 1'b1};
      ST_SLEEP: gates = '{core: 1'b0, bus: 1'b0, pll: 1'b1, snoop: 1'b0};
      default:  gates = '{core: 1'b0, bus: 1'b0, pll: 1'b1, snoop: 1'b0};
    endcase
  end
endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import lpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       sleep_req,
  input  logic       bclk_lost,
  output logic       core_clk_en,
  output logic       bus_clk_en,
  output logic       pll_en,
  output logic       ack_req,
  output logic       snoop_ok,
  output logic [1:0] state
);
  localparam int NREQ = 2;

  logic [NREQ-1:0] req_raw, req_s;
  lpc_state_e      cur;
  lpc_gates_t      gates;

  assign req_raw = {sleep_req, stop_req};

  lpc_sync #(.STAGES(SYNC_STAGES), .WIDTH(NREQ)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req_raw),
    .q    (req_s)
  );

  lpc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_s   (req_s[0]),
    .sleep_s  (req_s[1]),
    .bclk_lost(bclk_lost),
    .cur      (cur),
    .ack_pulse(ack_req)
  );

  lpc_gate_dec u_dec (
    .cur  (cur),
    .gates(gates)
  );

  assign core_clk_en = gates.core;
  assign bus_clk_en  = gates.bus;
  assign pll_en      = gates.pll;
  assign snoop_ok    = gates.snoop;
  assign state       = cur;
endmodule

// File: rtl/lp_state_ctrl_chk.sv
module lp_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bclk_lost,
  input logic       core_clk_en,
  input logic       bus_clk_en,
  input logic       pll_en,
  input logic       ack_req,
  input logic       snoop_ok,
  input logic [1:0] state
);
  p_ack_on_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (state == 2'd1 && $past(state) == 2'd0));

  p_stopg_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1) |-> (!core_clk_en && bus_clk_en && pll_en && snoop_ok));

  p_sleep_only_from_stopg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && $past(state) != 2'd2) |-> ($past(state) == 2'd1));

  p_sleep_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2) |-> (!core_clk_en && !bus_clk_en && pll_en && !snoop_ok));

  p_sleep_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'd2) |-> (state == 2'd2 || state == 2'd1 || state == 2'd3));

  p_lost_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_lost |=> (state == 2'd3));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'd3) |-> (state == 2'd3 && !snoop_ok && !bus_clk_en));
endmodule

bind lp_state_ctrl lp_state_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bclk_lost  (bclk_lost),
  .core_clk_en(core_clk_en),
  .bus_clk_en (bus_clk_en),
  .pll_en     (pll_en),
  .ack_req    (ack_req),
  .snoop_ok   (snoop_ok),
  .state      (state)
);

// File: tb/lp_state_ctrl_bench.sv
module lp_state_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, sleep_req = 1'b0, bclk_lost = 1'b0;
  logic core_clk_en, bus_clk_en, pll_en, ack_req, snoop_ok;
  logic [1:0] state;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lp_state_ctrl u_lp_state_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .sleep_req(sleep_req),
    .bclk_lost(bclk_lost), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
    .pll_en(pll_en), .ack_req(ack_req), .snoop_ok(snoop_ok), .state(state)
  );

  function automatic logic [1:0] mstep(logic [1:0] s, logic st, logic sl);
    case (s)
      2'd0: return st ? 2'd1 : 2'd0;
      2'd1: return !st ? 2'd0 : (sl ? 2'd2 : 2'd1);
      2'd2: return sl ? 2'd2 : 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [3:0] mgates(logic [1:0] s);
    case (s)
      2'd0: return 4'b1111;
      2'd1: return 4'b0111;
      default: return 4'b0010;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req, logic [1:0] es, int acks, int eacks);
    check(req, {30'd0, state}, {30'd0, es});
    check(req, {28'd0, core_clk_en, bus_clk_en, pll_en, snoop_ok},
          {28'd0, mgates(es)});
    check(req, acks, eacks);
  endtask

  task automatic do_reset();
    @(negedge clk);
    stop_req = 0; sleep_req = 0; bclk_lost = 0; rst_n = 0;
    @(negedge clk);
    check("R1", {26'd0, state, core_clk_en, bus_clk_en, pll_en, snoop_ok, ack_req},
          {26'd0, 2'd0, 5'b11110});
    rst_n = 1;
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] ms;
    int eack, acks;
    do_reset();

    // R10: exact latency of a stop request
    @(negedge clk); stop_req = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R10", {30'd0, state}, 32'd0);
    @(negedge clk);
    check("R10", {30'd0, state}, 32'd1);
    check("R2", {31'd0, ack_req}, 32'd1);
    @(negedge clk);
    check("R2", {31'd0, ack_req}, 32'd0);

    // R2 R3 R4 R5 R6 R7 R8: all three-step input sequences
    for (int seq = 0; seq < 64; seq++) begin
      do_reset();
      ms = 2'd0;
      for (int k = 0; k < 3; k++) begin
        logic st, sl;
        st = seq[2*k]; sl = seq[2*k+1];
        @(negedge clk); stop_req = st; sleep_req = sl;
        eack = 0;
        for (int it = 0; it < 3; it++) begin
          logic [1:0] n;
          n = mstep(ms, st, sl);
          if (ms == 2'd0 && n == 2'd1) eack++;
          ms = n;
        end
        acks = 0;
        for (int c = 0; c < 8; c++) begin
          @(negedge clk);
          if (ack_req) acks++;
        end
        case (ms)
          2'd0: check_outs(sl ? "R8/R7" : "R7", ms, acks, eack);
          2'd1: check_outs("R3/R2/R6", ms, acks, eack);
          default: check_outs("R4/R5", ms, acks, eack);
        endcase
      end
    end

    // R9: bus clock loss from each reachable state, then sticky
    for (int target = 0; target < 3; target++) begin
      do_reset();
      @(negedge clk);
      stop_req = (target != 0); sleep_req = (target == 2);
      repeat (8) @(negedge clk);
      check("R9", {30'd0, state}, target);
      bclk_lost = 1;
      @(negedge clk); bclk_lost = 0;
      check_outs("R9", 2'd3, 0, 0);
      stop_req = 0; sleep_req = 0;
      repeat (6) @(negedge clk);
      check_outs("R9", 2'd3, 0, 0);
      stop_req = 1;
      repeat (6) @(negedge clk);
      check_outs("R9", 2'd3, 0, 0);
    end
    do_reset();
    @(negedge clk);
    check("R1", {30'd0, state}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule